// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block picks, every clock cycle, which operation classes send their head instruction to execution. Each class queue shows one head entry: a valid bit, a squashed flag and the head's sequence number. The selector ranks the live heads from oldest to youngest and grants up to `ISSUE_WIDTH` of them in that order. A squashed head is dropped without using an issue slot. A class whose functional unit is not available is passed over, and younger classes still get their chance.

For each granted class the selector tracks when its functional unit comes free. A single-cycle operation, or a pipelined multi-cycle one, frees its unit on the next cycle. A non-pipelined multi-cycle operation keeps its unit until its completion notice, which comes `issueLat-1` cycles after issue. Until then the selector treats that class's unit as busy. Grants, head pops and the issued count are combinational within the cycle. Unit releases, completion notices and the running busy-event counter are registered.

Top module: `issue_select`

## Requirements
- R1: Live heads (valid and not squashed, with a unit available) are granted strictly oldest-first, where a smaller sequence number is older. No more than `ISSUE_WIDTH` grants are made in one cycle.
- R2: When two heads carry the same sequence number, the class with the lower index counts as older.
- R3: While `execReady` is low, no class is granted and no head is popped.
- R4: A squashed head is popped without a grant and uses no issue slot. It is popped only if fewer than `ISSUE_WIDTH` granted classes are older than it.
- R5: A live head that needs a unit (`needsUnit`=1) is blocked when `unitFree` is 0 or its unit is still held. A blocked head is skipped, and younger classes are still considered. Each skipped head within reach adds one to `busyCount` at the next clock edge.
- R6: A class with `needsUnit`=0 issues as a single-cycle operation, whatever `opLat` says. It produces no unit release and no completion notice.
- R7: A granted class with `needsUnit`=1 and `opLat`<=1 raises its `unitRelease` bit in the cycle after the grant, and raises no completion notice.
- R8: A granted class with `needsUnit`=1, `opLat`>1 and `issueLat`>1 raises `opComplete` and `unitRelease` together, `issueLat-1` cycles after the grant cycle. Until then the unit is held, so the class cannot be granted.
- R9: A granted class with `needsUnit`=1, `opLat`>1 and `issueLat`<=1 raises both `opComplete` and `unitRelease` in the cycle after the grant.
- R10: `issuedCount` equals the number of grants made in the current cycle.
- R11: After reset, `unitRelease`, `opComplete` and `busyCount` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| execReady | input | 1 | Execute stage can accept instructions this cycle |
| headValid | input | CLASS_COUNT | Class has a head entry |
| headSquashed | input | CLASS_COUNT | Head entry has been squashed |
| headSeq | input | CLASS_COUNT*SEQ_W | Head sequence numbers, class c in bits [c*SEQ_W +: SEQ_W] |
| needsUnit | input | CLASS_COUNT | Class executes on a functional unit |
| unitFree | input | CLASS_COUNT | Class's functional unit is available |
| opLat | input | CLASS_COUNT*LAT_W | Operation latency per class |
| issueLat | input | CLASS_COUNT*LAT_W | Issue latency per class (above 1 means non-pipelined) |
| issueGrant | output | CLASS_COUNT | Head issued this cycle |
| popHead | output | CLASS_COUNT | Remove head this cycle (issued or squashed) |
| issuedCount | output | CNT_W | Number of grants this cycle |
| unitRelease | output | CLASS_COUNT | Functional unit of the class is released |
| opComplete | output | CLASS_COUNT | Multi-cycle operation of the class completes |
| busyCount | output | BUSY_W | Running count of blocked-head events |

## Verification
A wrong age comparison or a wrong count of older granted classes shows up in the same cycle as a grant to the wrong class, or a pop of a squashed head that is out of reach. The stimulus table covers the orderings, tie, squash and busy patterns that expose this. A faulty unit timer shows only a cycle or more later: the completion or release edge lands one cycle off, or a held unit is granted again straight after issue. The directed tests probe exactly these cycles. A slip in counting busy events drifts `busyCount` without bound, so the final count after all stimulus exposes it.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;
  parameter int CLASS_COUNT = 4;

  typedef logic [CLASS_COUNT-1:0] classVec_t;

  // strobes from selection control to unit tracking datapath
  typedef struct packed {
    classVec_t grant;
    classVec_t relNextSet;
    classVec_t launchMulti;
    classVec_t busyEvt;
  } selStrobe_t;
endpackage

// File: rtl/issue_sel_ctrl.sv
module issue_sel_ctrl
  import issue_sel_pkg::*;
#(
  parameter int ISSUE_WIDTH = 2,
  parameter int SEQ_W       = 8,
  parameter int LAT_W       = 4,
  localparam int CNT_W      = $clog2(CLASS_COUNT + 1)
) (
  input  logic                         execReady,
  input  classVec_t                    headValid,
  input  classVec_t                    headSquashed,
  input  logic [CLASS_COUNT*SEQ_W-1:0] headSeq,
  input  classVec_t                    needsUnit,
  input  classVec_t                    unitFree,
  input  classVec_t                    unitHeld,
  input  logic [CLASS_COUNT*LAT_W-1:0] opLat,
  input  logic [CLASS_COUNT*LAT_W-1:0] issueLat,
  output selStrobe_t                   strobe,
  output classVec_t                    popHead,
  output logic [CNT_W-1:0]             issuedCount
);
  classVec_t live, blocked, elig, inReach, squashPop;
  logic [CNT_W-1:0] ahead [CLASS_COUNT];

  always_comb begin
    for (int c = 0; c < CLASS_COUNT; c++) begin
      live[c]    = headValid[c] & ~headSquashed[c];
      blocked[c] = needsUnit[c] & (~unitFree[c] | unitHeld[c]);
      elig[c]    = live[c] & ~blocked[c];
    end
    // count issuing classes that rank ahead of each class
    for (int c = 0; c < CLASS_COUNT; c++) begin
      ahead[c] = '0;
      for (int b = 0; b < CLASS_COUNT; b++) begin
        if (b != c && elig[b]) begin
          if ((headSeq[b*SEQ_W +: SEQ_W] < headSeq[c*SEQ_W +: SEQ_W]) ||
              ((headSeq[b*SEQ_W +: SEQ_W] == headSeq[c*SEQ_W +: SEQ_W]) && (b < c)))
            ahead[c] = ahead[c] + 1'b1;
        end
      end
      inReach[c] = execReady && (int'(ahead[c]) < ISSUE_WIDTH);
    end
  end

  always_comb begin
    strobe      = '0;
    issuedCount = '0;
    for (int c = 0; c < CLASS_COUNT; c++) begin
      strobe.grant[c]   = elig[c] & inReach[c];
      squashPop[c]      = headValid[c] & headSquashed[c] & inReach[c];
      strobe.busyEvt[c] = live[c] & blocked[c] & inReach[c];
      strobe.relNextSet[c] = strobe.grant[c] & needsUnit[c] &
                             ((opLat[c*LAT_W +: LAT_W] <= LAT_W'(1)) ||
                              (issueLat[c*LAT_W +: LAT_W] <= LAT_W'(1)));
      strobe.launchMulti[c] = strobe.grant[c] & needsUnit[c] &
                              (opLat[c*LAT_W +: LAT_W] > LAT_W'(1));
      popHead[c] = strobe.grant[c] | squashPop[c];
      issuedCount = issuedCount + CNT_W'(strobe.grant[c]);
    end
  end
endmodule

// File: rtl/issue_sel_track.sv
module issue_sel_track
  import issue_sel_pkg::*;
#(
  parameter int LAT_W  = 4,
  parameter int BUSY_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  selStrobe_t                   strobe,
  input  logic [CLASS_COUNT*LAT_W-1:0] issueLat,
  output classVec_t                    unitHeld,
  output classVec_t                    unitRelease,
  output classVec_t                    opComplete,
  output logic [BUSY_W-1:0]            busyCount
);
  localparam int EVT_W = $clog2(CLASS_COUNT + 1);

  classVec_t relNextQ;

  generate
    for (genvar c = 0; c < CLASS_COUNT; c++) begin : g_unit
      logic [LAT_W-1:0] timerQ;
      logic             nonPipeQ;
      logic [LAT_W-1:0] lat;
      logic [LAT_W-1:0] delay;

      assign lat   = issueLat[c*LAT_W +: LAT_W];
      assign delay = (lat > LAT_W'(1)) ? lat - LAT_W'(1) : LAT_W'(1);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          timerQ   <= '0;
          nonPipeQ <= 1'b0;
          relNextQ[c] <= 1'b0;
        end else begin
          relNextQ[c] <= strobe.relNextSet[c];
          if (strobe.launchMulti[c]) begin
            timerQ   <= delay;
            nonPipeQ <= (lat > LAT_W'(1));
          end else if (timerQ != '0) begin
            timerQ <= timerQ - LAT_W'(1);
          end
        end
      end

      assign opComplete[c]  = (timerQ == LAT_W'(1));
      assign unitHeld[c]    = (timerQ != '0) & nonPipeQ;
      assign unitRelease[c] = relNextQ[c] | (opComplete[c] & nonPipeQ);
    end
  endgenerate

  logic [EVT_W-1:0] evtSum;
  always_comb begin
    evtSum = '0;
    for (int c = 0; c < CLASS_COUNT; c++) evtSum = evtSum + EVT_W'(strobe.busyEvt[c]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCount <= '0;
    else       busyCount <= busyCount + BUSY_W'(evtSum);
  end
endmodule

// File: rtl/issue_select.sv
module issue_select
  import issue_sel_pkg::*;
#(
  parameter int ISSUE_WIDTH = 2,
  parameter int SEQ_W       = 8,
  parameter int LAT_W       = 4,
  parameter int BUSY_W      = 16,
  localparam int CNT_W      = $clog2(CLASS_COUNT + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         execReady,
  input  logic [CLASS_COUNT-1:0]       headValid,
  input  logic [CLASS_COUNT-1:0]       headSquashed,
  input  logic [CLASS_COUNT*SEQ_W-1:0] headSeq,
  input  logic [CLASS_COUNT-1:0]       needsUnit,
  input  logic [CLASS_COUNT-1:0]       unitFree,
  input  logic [CLASS_COUNT*LAT_W-1:0] opLat,
  input  logic [CLASS_COUNT*LAT_W-1:0] issueLat,
  output logic [CLASS_COUNT-1:0]       issueGrant,
  output logic [CLASS_COUNT-1:0]       popHead,
  output logic [CNT_W-1:0]             issuedCount,
  output logic [CLASS_COUNT-1:0]       unitRelease,
  output logic [CLASS_COUNT-1:0]       opComplete,
  output logic [BUSY_W-1:0]            busyCount
);
  selStrobe_t strobe;
  classVec_t  unitHeld;

  issue_sel_ctrl #(
    .ISSUE_WIDTH(ISSUE_WIDTH), .SEQ_W(SEQ_W), .LAT_W(LAT_W)
  ) u_ctrl (
    .execReady(execReady), .headValid(headValid), .headSquashed(headSquashed),
    .headSeq(headSeq), .needsUnit(needsUnit), .unitFree(unitFree),
    .unitHeld(unitHeld), .opLat(opLat), .issueLat(issueLat),
    .strobe(strobe), .popHead(popHead), .issuedCount(issuedCount)
  );

  issue_sel_track #(
    .LAT_W(LAT_W), .BUSY_W(BUSY_W)
  ) u_track (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueLat(issueLat),
    .unitHeld(unitHeld), .unitRelease(unitRelease),
    .opComplete(opComplete), .busyCount(busyCount)
  );

  assign issueGrant = strobe.grant;
endmodule

// File: rtl/issue_select_checker.sv
module issue_select_checker
  import issue_sel_pkg::*;
#(
  parameter int ISSUE_WIDTH = 2,
  parameter int LAT_W       = 4,
  parameter int BUSY_W      = 16,
  localparam int CNT_W      = $clog2(CLASS_COUNT + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         execReady,
  input logic [CLASS_COUNT-1:0]       headValid,
  input logic [CLASS_COUNT-1:0]       headSquashed,
  input logic [CLASS_COUNT-1:0]       needsUnit,
  input logic [CLASS_COUNT*LAT_W-1:0] opLat,
  input logic [CLASS_COUNT-1:0]       issueGrant,
  input logic [CLASS_COUNT-1:0]       popHead,
  input logic [CNT_W-1:0]             issuedCount,
  input logic [CLASS_COUNT-1:0]       unitRelease,
  input logic [BUSY_W-1:0]            busyCount
);
  assert_width_cap_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(issueGrant) <= ISSUE_WIDTH);

  assert_grant_live_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issueGrant & ~(headValid & ~headSquashed)) == '0);

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    !execReady |-> (issueGrant == '0 && popHead == '0));

  assert_pop_reason_R4: assert property (@(posedge clk) disable iff (!rstN)
    (popHead & ~issueGrant & ~(headValid & headSquashed)) == '0);

  assert_busy_monotonic_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> busyCount >= $past(busyCount));

  assert_count_match_R10: assert property (@(posedge clk) disable iff (!rstN)
    int'(issuedCount) == $countones(issueGrant));

  generate
    for (genvar c = 0; c < CLASS_COUNT; c++) begin : g_cls
      assert_single_release_R7: assert property (@(posedge clk) disable iff (!rstN)
        (issueGrant[c] && needsUnit[c] && opLat[c*LAT_W +: LAT_W] <= LAT_W'(1))
        |=> unitRelease[c]);
    end
  endgenerate
endmodule

bind issue_select issue_select_checker #(
  .ISSUE_WIDTH(ISSUE_WIDTH), .LAT_W(LAT_W), .BUSY_W(BUSY_W)
) u_checker (
  .clk(clk), .rstN(rstN), .execReady(execReady), .headValid(headValid),
  .headSquashed(headSquashed), .needsUnit(needsUnit), .opLat(opLat),
  .issueGrant(issueGrant), .popHead(popHead), .issuedCount(issuedCount),
  .unitRelease(unitRelease), .busyCount(busyCount)
);

// File: tb/issue_select_bench.sv
module issue_select_bench;
  localparam int C = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execReady = 1'b0;
  logic [3:0]  headValid = '0, headSquashed = '0, needsUnit = '0, unitFree = '0;
  logic [31:0] headSeq = '0;
  logic [15:0] opLat = {4{4'd1}}, issueLat = {4{4'd1}};
  logic [3:0]  issueGrant, popHead, unitRelease, opComplete;
  logic [2:0]  issuedCount;
  logic [15:0] busyCount;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  issue_select u_issue_select (
    .clk(clk), .rstN(rstN), .execReady(execReady), .headValid(headValid),
    .headSquashed(headSquashed), .headSeq(headSeq), .needsUnit(needsUnit),
    .unitFree(unitFree), .opLat(opLat), .issueLat(issueLat),
    .issueGrant(issueGrant), .popHead(popHead), .issuedCount(issuedCount),
    .unitRelease(unitRelease), .opComplete(opComplete), .busyCount(busyCount)
  );

  // {valid, squashed, needsUnit, unitFree, seq c3..c0, execReady, expGrant, expPop}
  localparam logic [56:0] VECS [9] = '{
    {4'b1111, 4'b0000, 4'b0000, 4'b1111, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b1, 4'b1010, 4'b1010},
    {4'b1111, 4'b0000, 4'b0000, 4'b1111, {8'd5,  8'd9,  8'd5,  8'd5},  1'b1, 4'b0011, 4'b0011},
    {4'b1111, 4'b0010, 4'b0000, 4'b1111, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b1, 4'b1100, 4'b1110},
    {4'b1111, 4'b0000, 4'b1111, 4'b1101, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b1, 4'b1100, 4'b1100},
    {4'b1111, 4'b0010, 4'b0000, 4'b1111, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b0, 4'b0000, 4'b0000},
    {4'b0100, 4'b0000, 4'b0000, 4'b1111, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b1, 4'b0100, 4'b0100},
    {4'b0000, 4'b0000, 4'b0000, 4'b1111, {8'd20, 8'd30, 8'd10, 8'd40}, 1'b1, 4'b0000, 4'b0000},
    {4'b1111, 4'b0100, 4'b0000, 4'b1111, {8'd4,  8'd3,  8'd2,  8'd1},  1'b1, 4'b0011, 4'b0011},
    {4'b1111, 4'b0011, 4'b0000, 4'b1111, {8'd4,  8'd3,  8'd2,  8'd1},  1'b1, 4'b1100, 4'b1111}
  };
  localparam string VTAG [9] = '{"R1", "R2", "R4", "R5", "R3", "R1", "R1", "R4", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    headValid = '0; headSquashed = '0; needsUnit = '0; unitFree = 4'hF;
    opLat = {4{4'd1}}; issueLat = {4{4'd1}}; execReady = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    chk("R11 release", 32'(unitRelease), 0);
    chk("R11 complete", 32'(opComplete), 0);
    chk("R11 busy", 32'(busyCount), 0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {headValid, headSquashed, needsUnit, unitFree, headSeq, execReady} = VECS[i][56:8];
      #1;
      chk({VTAG[i], " grant"}, 32'(issueGrant), 32'(VECS[i][7:4]));
      chk({VTAG[i], " pop"}, 32'(popHead), 32'(VECS[i][3:0]));
      chk("R10 count", 32'(issuedCount), 32'($countones(VECS[i][7:4])));
    end
    @(negedge clk); idle();
    @(negedge clk);
    chk("R5 busy after table", 32'(busyCount), 1);

    // R7: single-cycle op with unit
    @(negedge clk); headValid = 4'b0001; needsUnit = 4'b0001; headSeq = '0;
    #1 chk("R7 grant", 32'(issueGrant), 1);
    @(posedge clk); #1 headValid = '0;
    chk("R7 release next cycle", 32'(unitRelease), 1);
    chk("R7 no completion", 32'(opComplete), 0);
    @(posedge clk); #1 chk("R7 release one cycle", 32'(unitRelease), 0);

    // R8: non-pipelined multi-cycle, issueLat=4 -> completes 3 cycles later
    @(negedge clk); idle(); headValid = 4'b0100; needsUnit = 4'b0100;
    opLat[11:8] = 4'd3; issueLat[11:8] = 4'd4;
    #1 chk("R8 grant", 32'(issueGrant), 4);
    @(posedge clk); #1;
    chk("R8 unit held", 32'(issueGrant), 0);
    chk("R8 no early release", 32'(unitRelease), 0);
    @(posedge clk); #1 headValid = '0;
    chk("R8 no early complete", 32'(opComplete), 0);
    @(posedge clk); #1;
    chk("R8 complete", 32'(opComplete), 4);
    chk("R8 release", 32'(unitRelease), 4);
    @(posedge clk); #1 chk("R8 complete ends", 32'(opComplete | unitRelease), 0);
    chk("R5 busy on held unit", 32'(busyCount), 2);

    // R9: pipelined multi-cycle
    @(negedge clk); idle(); headValid = 4'b1000; needsUnit = 4'b1000;
    opLat[15:12] = 4'd3; issueLat[15:12] = 4'd1;
    #1 chk("R9 grant", 32'(issueGrant), 8);
    @(posedge clk); #1 headValid = '0;
    chk("R9 complete", 32'(opComplete), 8);
    chk("R9 release", 32'(unitRelease), 8);
    @(posedge clk); #1 chk("R9 ends", 32'(opComplete | unitRelease), 0);

    // R6: no-unit class with long opLat issues as single-cycle
    @(negedge clk); idle(); headValid = 4'b0010; opLat[7:4] = 4'd5; issueLat[7:4] = 4'd5;
    #1 chk("R6 grant", 32'(issueGrant), 2);
    @(posedge clk); #1 headValid = '0;
    chk("R6 no release/complete", 32'(opComplete | unitRelease), 0);
    @(posedge clk); #1 chk("R6 still quiet", 32'(opComplete | unitRelease), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule